// File: doc/BRIEF.md
# Nested Priority Event Controller

This block sits beside a processor core and decides which of sixteen event levels the core should service next. Level 0 is the most urgent and level 15 the least. Each level has a bit in three registers. The capture register records events that have arrived. The enable register says which levels may be serviced. The nesting register records which levels are currently being serviced, either active or preempted by a more urgent level.

An event request line that goes high sets its capture bit. The controller then presents the most urgent serviceable level to the core through `req_o` and `vec_o`. It does so only when that level is more urgent than every level already in service. When the core raises `ack_i`, the presented level moves from captured to in service. A `ret_i` strobe ends the innermost level in service.

Levels 0 to 6 are fixed-function levels: emulation, reset, nonmaskable, exception, reserved, hardware error and core timer. Levels 7 to 15 are general-purpose and are also gated by a global enable. Software reaches the registers through a small port. Access to the enable and nesting registers is qualified by a privilege input.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the capture, enable and nesting registers all read 0 and `req_o` is 0.
- R2: A 1 on `evt_req_i[k]` at a clock edge sets capture bit k. The bit stays set until level k is accepted or software clears it.
- R3: A write to address 0 (capture register) changes only the bits whose enable bit is 0. Bits whose enable bit is 1 keep their value.
- R4: Levels 5 to 15 with enable bit 0 are never presented, and their capture bit stays set.
- R5: Levels 0 to 3 are serviceable whatever their enable bit is. Level 4 is never presented.
- R6: While `gie_i` is 0, levels 7 to 15 are not presented. Levels 0 to 6 are unaffected.
- R7: Among serviceable captured levels, the lowest-numbered one is presented, and `vec_o` carries its number.
- R8: A level is presented only if no nesting bit is set at its own number or at any lower number.
- R9: When `ack_i` is 1 while `req_o` is 1, the presented level's capture bit clears and its nesting bit sets at that same clock edge. Clearing wins over a capture of the same level in that cycle.
- R10: A `ret_i` strobe clears the lowest-numbered set nesting bit and no other bit.
- R11: A write to address 1 (enable register) takes effect only while `sup_i` is 1. Reads of address 1 or address 2 (nesting register) return 0 while `sup_i` is 0.
- R12: Writes to address 2 or address 3 have no effect. Address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_req_i | input | 16 | Event request lines, bit k for level k |
| gie_i | input | 1 | Global enable for levels 7 to 15 |
| sup_i | input | 1 | Privileged-mode qualifier for register access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | 0 capture, 1 enable, 2 nesting, 3 unused |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| ack_i | input | 1 | Core accepts the presented level |
| ret_i | input | 1 | Return strobe, ends the innermost level in service |
| req_o | output | 1 | A level is presented for service |
| vec_o | output | 4 | Number of the presented level |

## Verification
The bench drives every level alone, once with all enable bits clear and once with all set. This catches a design that lets level 4 through, one that blocks levels 0 to 3 when their enable bit is clear, and one that drops a blocked capture instead of holding it.

Nesting sequences check three cases:
- A design that compares against the wrong end of the nesting register would let a less urgent level in.
- A design that uses "less or equal" in the preemption rule would let an equal level in.
- A design whose return strobe clears the wrong bit would release blocked levels in the wrong order.

Privileged access, write filtering of the capture register and the global enable are each probed through the register port. A leaky gate there shows up as a changed readback.

// File: rtl/evt_nest_pkg.sv
package evt_nest_pkg;
  typedef enum logic [1:0] {
    RA_CAPT = 2'd0,
    RA_ENAB = 2'd1,
    RA_NEST = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evt_capture_bank.sv
module evt_capture_bank #(
  parameter int N_LVL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] evt_req,
  input  logic             wr_capt,
  input  logic             wr_enab,
  input  logic [N_LVL-1:0] wdata,
  input  logic [N_LVL-1:0] clr_oh,
  output logic [N_LVL-1:0] capt_q,
  output logic [N_LVL-1:0] enab_q
);
  logic [N_LVL-1:0] capt_d;
  logic             capt_en;

  // software write touches only bits whose enable bit is clear (R3),
  // then new captures merge, then an accept clears (R9 precedence)
  always_comb begin
    capt_d = capt_q;
    if (wr_capt) capt_d = (capt_q & enab_q) | (wdata & ~enab_q);
    capt_d  = (capt_d | evt_req) & ~clr_oh;
    capt_en = wr_capt | (|evt_req) | (|clr_oh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       capt_q <= '0;
    else if (capt_en) capt_q <= capt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enab_q <= '0;
    else if (wr_enab) enab_q <= wdata;
  end
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
  parameter int N_LVL    = 16,
  parameter int FIRST_GP = 7,
  parameter int N_NOMASK = 4,
  parameter int RSVD_LVL = 4,
  localparam int IW      = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] capt_q,
  input  logic [N_LVL-1:0] enab_q,
  input  logic [N_LVL-1:0] nest_q,
  input  logic             gie,
  output logic             req,
  output logic [IW-1:0]    vec,
  output logic [N_LVL-1:0] sel_oh,
  output logic [N_LVL-1:0] nest_low_oh
);
  logic [N_LVL-1:0] elig;
  logic [N_LVL-1:0] cand_oh;

  for (genvar g = 0; g < N_LVL; g++) begin : g_elig
    if (g == RSVD_LVL) begin : g_rsvd
      assign elig[g] = 1'b0;
    end else if (g < N_NOMASK) begin : g_fixed
      assign elig[g] = capt_q[g];
    end else if (g < FIRST_GP) begin : g_sys
      assign elig[g] = capt_q[g] & enab_q[g];
    end else begin : g_gp
      assign elig[g] = capt_q[g] & enab_q[g] & gie;
    end
  end

  // isolate lowest set bits; lower level means smaller one-hot value
  always_comb begin
    cand_oh     = elig & (~elig + N_LVL'(1));
    nest_low_oh = nest_q & (~nest_q + N_LVL'(1));
    req         = (|elig) & ((nest_q == '0) | (cand_oh < nest_low_oh));
    sel_oh      = req ? cand_oh : '0;
    vec         = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (cand_oh[i]) vec = vec | IW'(i);
    end
  end
endmodule

// File: rtl/evt_nest_track.sv
module evt_nest_track #(
  parameter int N_LVL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] set_oh,
  input  logic             ret,
  input  logic [N_LVL-1:0] low_oh,
  output logic [N_LVL-1:0] nest_q
);
  logic [N_LVL-1:0] nest_d;
  logic             nest_en;

  always_comb begin
    nest_d  = (nest_q & ~(ret ? low_oh : '0)) | set_oh;
    nest_en = ret | (|set_oh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nest_q <= '0;
    else if (nest_en) nest_q <= nest_d;
  end
endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl
  import evt_nest_pkg::*;
#(
  parameter int N_LVL    = 16,
  parameter int FIRST_GP = 7,
  parameter int N_NOMASK = 4,
  parameter int RSVD_LVL = 4,
  localparam int IW      = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] evt_req_i,
  input  logic             gie_i,
  input  logic             sup_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [N_LVL-1:0] reg_wdata_i,
  output logic [N_LVL-1:0] reg_rdata_o,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             req_o,
  output logic [IW-1:0]    vec_o
);
  reg_addr_e        addr;
  logic             wr_capt, wr_enab;
  logic [N_LVL-1:0] capt_q, enab_q, nest_q;
  logic [N_LVL-1:0] sel_oh, nest_low_oh, acc_oh;
  logic             req;
  logic [IW-1:0]    vec;

  always_comb begin
    addr    = reg_addr_e'(reg_addr_i);
    wr_capt = reg_wr_i & (addr == RA_CAPT);
    wr_enab = reg_wr_i & (addr == RA_ENAB) & sup_i;
    acc_oh  = ack_i ? sel_oh : '0;
  end

  evt_capture_bank #(.N_LVL(N_LVL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_req (evt_req_i),
    .wr_capt (wr_capt),
    .wr_enab (wr_enab),
    .wdata   (reg_wdata_i),
    .clr_oh  (acc_oh),
    .capt_q  (capt_q),
    .enab_q  (enab_q)
  );

  evt_arbiter #(
    .N_LVL    (N_LVL),
    .FIRST_GP (FIRST_GP),
    .N_NOMASK (N_NOMASK),
    .RSVD_LVL (RSVD_LVL)
  ) u_arb (
    .capt_q      (capt_q),
    .enab_q      (enab_q),
    .nest_q      (nest_q),
    .gie         (gie_i),
    .req         (req),
    .vec         (vec),
    .sel_oh      (sel_oh),
    .nest_low_oh (nest_low_oh)
  );

  evt_nest_track #(.N_LVL(N_LVL)) u_nest (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_oh (acc_oh),
    .ret    (ret_i),
    .low_oh (nest_low_oh),
    .nest_q (nest_q)
  );

  always_comb begin
    req_o = req;
    vec_o = vec;
    unique case (addr)
      RA_CAPT: reg_rdata_o = capt_q;
      RA_ENAB: reg_rdata_o = sup_i ? enab_q : '0;
      RA_NEST: reg_rdata_o = sup_i ? nest_q : '0;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_nest_chk.sv
module evt_nest_chk #(
  parameter int N_LVL    = 16,
  parameter int FIRST_GP = 7,
  parameter int RSVD_LVL = 4,
  localparam int IW      = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_o,
  input logic [IW-1:0]    vec_o,
  input logic             ack_i,
  input logic             ret_i,
  input logic             gie_i,
  input logic             sup_i,
  input logic [1:0]       reg_addr_i,
  input logic [N_LVL-1:0] reg_rdata_o,
  input logic [N_LVL-1:0] capt_q,
  input logic [N_LVL-1:0] nest_q
);
  p_rsvd_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> vec_o != IW'(RSVD_LVL));

  p_gie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gie_i) |-> vec_o < IW'(FIRST_GP));

  p_nest_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (nest_q & ({N_LVL{1'b1}} >> (N_LVL - 1 - int'(vec_o)))) == '0);

  p_accept_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> nest_q[$past(vec_o)] && !capt_q[$past(vec_o)]);

  p_return_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !(req_o && ack_i) && nest_q != '0)
      |=> $countones(nest_q) == $countones($past(nest_q)) - 1);

  p_priv_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_i && (reg_addr_i == 2'd1 || reg_addr_i == 2'd2)) |-> reg_rdata_o == '0);
endmodule

bind evt_nest_ctrl evt_nest_chk #(
  .N_LVL    (N_LVL),
  .FIRST_GP (FIRST_GP),
  .RSVD_LVL (RSVD_LVL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_o       (req_o),
  .vec_o       (vec_o),
  .ack_i       (ack_i),
  .ret_i       (ret_i),
  .gie_i       (gie_i),
  .sup_i       (sup_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .capt_q      (capt_q),
  .nest_q      (nest_q)
);

// File: tb/evt_nest_ctrl_test.sv
module evt_nest_ctrl_test;
  localparam int  CLK_NS = 8;
  localparam logic [1:0] A_CAPT = 2'd0, A_ENAB = 2'd1, A_NEST = 2'd2, A_NONE = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt_req;
  logic        gie, sup, reg_wr, ack, ret;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        req;
  logic [3:0]  vec;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_NS/2) clk = ~clk;

  evt_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_req_i(evt_req), .gie_i(gie), .sup_i(sup),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .ack_i(ack), .ret_i(ret), .req_o(req), .vec_o(vec)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic s);
    reg_addr = a; reg_wdata = d; sup = s; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; sup = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, input logic s, output logic [15:0] d);
    reg_addr = a; sup = s;
    #1;
    d = reg_rdata;
    sup = 1'b1;
  endtask

  task automatic pulse(input logic [15:0] bits);
    evt_req = bits; tick(); evt_req = '0;
  endtask

  task automatic accept();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic retire();
    ret = 1'b1; tick(); ret = 1'b0;
  endtask

  function automatic logic serviceable(input int lvl, input logic [15:0] m, input logic g);
    if (lvl == 4) return 1'b0;
    if (lvl < 4)  return 1'b1;
    if (lvl >= 7 && !g) return 1'b0;
    return m[lvl];
  endfunction

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] m;
    rst_n = 1'b0; evt_req = '0; gie = 1'b1; sup = 1'b1; reg_wr = 1'b0;
    reg_addr = A_CAPT; reg_wdata = '0; ack = 1'b0; ret = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 req", req, 0);
    rd(A_CAPT, 1, d); chk("R1 capt", d, 0);
    rd(A_ENAB, 1, d); chk("R1 enab", d, 0);
    rd(A_NEST, 1, d); chk("R1 nest", d, 0);

    // sweep every level under enable all-clear and all-set
    for (int pass = 0; pass < 2; pass++) begin
      m = (pass == 0) ? 16'h0000 : 16'hFFFF;
      wr(A_ENAB, m, 1);
      for (int i = 0; i < 16; i++) begin
        pulse(16'(1) << i);
        rd(A_CAPT, 1, d); chk("R2 capture", d, 16'(1) << i);
        chk("R4/R5 req", req, serviceable(i, m, 1'b1));
        if (serviceable(i, m, 1'b1)) begin
          chk("R7 vec", vec, i);
          accept();
          rd(A_CAPT, 1, d); chk("R9 capt cleared", d, 0);
          rd(A_NEST, 1, d); chk("R9 nest set", d, 16'(1) << i);
          retire();
          rd(A_NEST, 1, d); chk("R10 nest cleared", d, 0);
        end else begin
          tick();
          rd(A_CAPT, 1, d); chk("R4 capture held", d, 16'(1) << i);
          chk("R4 still idle", req, 0);
          wr(A_ENAB, 16'h0000, 1);
          wr(A_CAPT, 16'h0000, 1);
          wr(A_ENAB, m, 1);
        end
      end
    end

    // R3 write filtering of the capture register
    wr(A_ENAB, 16'hFF00, 1);
    wr(A_CAPT, 16'hFFFF, 1);
    rd(A_CAPT, 1, d); chk("R3 filtered set", d, 16'h00FF);
    pulse(16'h1000);
    wr(A_CAPT, 16'h0000, 1);
    rd(A_CAPT, 1, d); chk("R3 enabled bit kept", d, 16'h1000);
    wr(A_ENAB, 16'h0000, 1);
    wr(A_CAPT, 16'h0000, 1);
    rd(A_CAPT, 1, d); chk("R3 cleared", d, 0);

    // R11 privileged access, R12 dead addresses
    wr(A_ENAB, 16'hFFFF, 1);
    wr(A_ENAB, 16'h0000, 0);
    rd(A_ENAB, 1, d); chk("R11 unprivileged write ignored", d, 16'hFFFF);
    rd(A_ENAB, 0, d); chk("R11 unprivileged enab read", d, 0);
    wr(A_NONE, 16'hFFFF, 1);
    rd(A_NONE, 1, d); chk("R12 addr3 read", d, 0);
    rd(A_CAPT, 1, d); chk("R12 addr3 write no effect", d, 0);

    // R8 nesting and preemption
    pulse(16'h0400);
    chk("R8 vec10", vec, 10);
    accept();
    pulse(16'h1000);
    chk("R8 less urgent blocked", req, 0);
    rd(A_NEST, 0, d); chk("R11 unprivileged nest read", d, 0);
    wr(A_NEST, 16'hFFFF, 1);
    rd(A_NEST, 1, d); chk("R12 nest not writable", d, 16'h0400);
    pulse(16'h0400);
    chk("R8 equal level blocked", req, 0);
    wr(A_ENAB, 16'h0000, 1);
    wr(A_CAPT, 16'h0000, 1);
    wr(A_ENAB, 16'hFFFF, 1);
    pulse(16'h1000);
    pulse(16'h0020);
    chk("R8 preempt req", req, 1);
    chk("R8 preempt vec5", vec, 5);
    accept();
    rd(A_NEST, 1, d); chk("R8 two nested", d, 16'h0420);
    retire();
    rd(A_NEST, 1, d); chk("R10 innermost removed", d, 16'h0400);
    chk("R8 still blocked", req, 0);
    retire();
    chk("R8 released req", req, 1);
    chk("R8 released vec12", vec, 12);
    accept(); retire();

    // R6 global enable
    gie = 1'b0;
    pulse(16'h0140);
    chk("R6 vec6", vec, 6);
    accept(); retire();
    chk("R6 gp blocked", req, 0);
    gie = 1'b1;
    #1;
    chk("R6 gp released", req, 1);
    chk("R6 vec8", vec, 8);
    accept(); retire();

    // R7 priority among simultaneous captures, R9 clear beats capture
    pulse(16'h4208);
    chk("R7 lowest first", vec, 3);
    evt_req = 16'h0008; ack = 1'b1; tick(); evt_req = '0; ack = 1'b0;
    rd(A_CAPT, 1, d); chk("R9 clear wins", d, 16'h4200);
    chk("R8 all blocked under 3", req, 0);
    retire();
    chk("R7 next vec9", vec, 9);
    accept(); retire();
    chk("R7 next vec14", vec, 14);
    accept(); retire();
    chk("R7 drained", req, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule